// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Memory Device

This block is the serial test port of a memory device. A test clock, a mode-select line, a serial data input and an active-low asynchronous test reset drive a 16-state controller. Shifting through the port loads a 3-bit instruction register. The current instruction then selects one of three data registers and sets two pin-control outputs. The data registers are a 1-bit bypass stage, a 32-bit identification register and a 109-cell boundary chain.

The boundary chain captures a parallel vector of pin states and presents a separately latched parallel vector toward the pins. The pads themselves are outside the block. One control output forces every functional output to high impedance. The other makes the outputs drive from the boundary chain's latched vector. Serial output leaves on the falling test-clock edge, and its enable is high only while a register is being shifted.

Top module: `scan_tap`

## Requirements
- R1: The 16-state controller reaches Test-Logic-Reset from any state after five consecutive rising TCK edges with TMS high. Driving trst_n low puts it there at once, without a clock.
- R2: In Capture-IR the instruction shift stage loads 3'b001, so a 1 leaves first. Shift-IR moves tdi into bit 2 and bit 0 out toward tdo. The shifted value becomes the active instruction on the falling TCK edge in Update-IR.
- R3: The active instruction is IDCODE (3'b001) after trst_n and whenever the controller is in Test-Logic-Reset.
- R4: Under IDCODE, Capture-DR loads the 32-bit ID_CODE parameter and Shift-DR sends it out least significant bit first.
- R5: BYPASS (3'b111) and the unused codes 3'b011, 3'b101 and 3'b110 select the 1-bit bypass stage. This stage captures 0. These codes leave pins_hiz and pins_from_bsr low.
- R6: Under SAMPLE/PRELOAD (3'b100), Capture-DR loads pin_in into the 109-cell chain and the controls stay low. Update-DR copies the chain (cell 0 nearest tdo) to bsr_out. bsr_out is 0 after trst_n.
- R7: Under EXTEST (3'b000), pins_from_bsr is high from the falling edge in Update-IR. The chain captures pin_in, and Update-DR refreshes bsr_out.
- R8: Under SAMPLE-Z (3'b010), pins_hiz is high and the chain captures pin_in. Update-DR leaves bsr_out unchanged. pins_hiz and pins_from_bsr are never high together.
- R9: tdo changes on the falling TCK edge and carries bit 0 of the register being shifted. tdo_oe is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Serial output enable |
| pin_in | input | BSR_LEN | Pin states captured into the boundary chain |
| bsr_out | output | BSR_LEN | Latched boundary vector toward the pins |
| pins_hiz | output | 1 | Force all functional outputs to high impedance |
| pins_from_bsr | output | 1 | Drive functional outputs from bsr_out |

## Verification
The hardest cases to reach are a reset by TMS alone that starts deep inside a data shift with EXTEST active, and a trst_n pulse that lands between clock edges while SAMPLE-Z is active. The bench drives the port into Shift-DR, holds TMS high, and checks that pins_from_bsr stays up for four edges and drops on the fifth. It pulses trst_n in the middle of a low clock phase and checks the outputs before the next edge. The chain length is shown by shifting 110 bits under SAMPLE/PRELOAD, so the last bit read out is the first bit shifted in.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {DSEL_BYP, DSEL_ID, DSEL_BSR} dsel_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  function automatic dsel_e op_dsel(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:                       return DSEL_ID;
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return DSEL_BSR;
      default:                         return DSEL_BYP;
    endcase
  endfunction

  function automatic logic op_hiz(input logic [IR_W-1:0] op);
    return op == OP_SAMPLEZ;
  endfunction

  function automatic logic op_drive(input logic [IR_W-1:0] op);
    return op == OP_EXTEST;
  endfunction

  function automatic logic op_bsr_upd(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPLE);
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e st
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= tap_next(st, tms);
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_st_e         st,
  output logic [IR_W-1:0] ir_cur,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              ir_sr <= IR_CAPTURE;
    else if (st == ST_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (st == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)              ir_cur <= OP_IDCODE;
    else if (st == ST_TLR)    ir_cur <= OP_IDCODE;
    else if (st == ST_UPD_IR) ir_cur <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int              BSR_LEN = 109,
  parameter logic [ID_W-1:0] ID_CODE = 32'h2C4B_1A53
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_st_e            st,
  input  dsel_e              dsel,
  input  logic               upd_en,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] bsr_out,
  output logic               dr_lsb
);

  logic               byp_q;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q  <= 1'b0;
      id_sr  <= ID_CODE;
      bsr_sr <= '0;
    end else if (st == ST_CAP_DR) begin
      case (dsel)
        DSEL_BYP: byp_q  <= 1'b0;
        DSEL_ID:  id_sr  <= ID_CODE;
        default:  bsr_sr <= pin_in;
      endcase
    end else if (st == ST_SH_DR) begin
      case (dsel)
        DSEL_BYP: byp_q  <= tdi;
        DSEL_ID:  id_sr  <= {tdi, id_sr[ID_W-1:1]};
        default:  bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                          bsr_out <= '0;
    else if (st == ST_UPD_DR && upd_en)   bsr_out <= bsr_sr;
  end

  always_comb begin
    case (dsel)
      DSEL_BYP: dr_lsb = byp_q;
      DSEL_ID:  dr_lsb = id_sr[0];
      default:  dr_lsb = bsr_sr[0];
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int              BSR_LEN = 109,
  parameter logic [ID_W-1:0] ID_CODE = 32'h2C4B_1A53
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] bsr_out,
  output logic               pins_hiz,
  output logic               pins_from_bsr
);

  tap_st_e         st;
  logic [IR_W-1:0] ir_cur;
  logic            ir_lsb;
  logic            dr_lsb;
  dsel_e           dsel;
  logic            in_shift;

  scan_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st)
  );

  scan_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st),
    .ir_cur(ir_cur), .ir_lsb(ir_lsb)
  );

  assign dsel = op_dsel(ir_cur);

  scan_tap_dr #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .dsel(dsel),
    .upd_en(op_bsr_upd(ir_cur)), .pin_in(pin_in), .bsr_out(bsr_out),
    .dr_lsb(dr_lsb)
  );

  assign in_shift = (st == ST_SH_IR) || (st == ST_SH_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (st == ST_SH_IR) ? ir_lsb : dr_lsb;
      tdo_oe <= in_shift;
    end
  end

  assign pins_hiz      = op_hiz(ir_cur);
  assign pins_from_bsr = op_drive(ir_cur);

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 109
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input logic               tdo_oe,
  input logic               pins_hiz,
  input logic               pins_from_bsr,
  input logic [BSR_LEN-1:0] bsr_out,
  input tap_st_e            st,
  input logic [IR_W-1:0]    ir_cur
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     hi_cnt <= 3'd0;
    else if (!tms)   hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  a_r1_five_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt == 3'd5) |-> (st == ST_TLR));

  a_r2_ir_changes_on_update: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_cur) |-> (st == ST_UPD_IR || st == ST_TLR));

  a_r3_tlr_holds_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR) |-> (ir_cur == OP_IDCODE));

  a_r6_bsr_out_only_on_update: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(bsr_out) |-> (st == ST_UPD_DR || st == ST_TLR));

  a_r8_hiz_keeps_bsr_out: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_UPD_DR && ir_cur == OP_SAMPLEZ) |-> $stable(bsr_out));

  a_r8_controls_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    !(pins_hiz && pins_from_bsr));

  a_r9_oe_only_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == ST_SH_IR || st == ST_SH_DR));

endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_oe(tdo_oe),
  .pins_hiz(pins_hiz), .pins_from_bsr(pins_from_bsr), .bsr_out(bsr_out),
  .st(st), .ir_cur(ir_cur)
);

// File: tb/scan_tap_tb.sv
module scan_tap_tb;

  localparam int          BSR_LEN = 109;
  localparam logic [31:0] ID_CODE = 32'h2C4B_1A53;
  localparam int          VW = 128;

  typedef struct packed {
    logic [2:0] op;
    logic       hiz;
    logic       drv;
    logic [3:0] probe;
  } vec_t;

  // probe: four bits read out while shifting in 4'b1011
  // bypass -> 0,1,1,0 ; id -> low nibble of ID_CODE ; chain -> pin_in[3:0]=9
  localparam vec_t VECS [8] = '{
    '{3'b000, 1'b0, 1'b1, 4'h9},
    '{3'b001, 1'b0, 1'b0, 4'h3},
    '{3'b010, 1'b1, 1'b0, 4'h9},
    '{3'b011, 1'b0, 1'b0, 4'h6},
    '{3'b100, 1'b0, 1'b0, 4'h9},
    '{3'b101, 1'b0, 1'b0, 4'h6},
    '{3'b110, 1'b0, 1'b0, 4'h6},
    '{3'b111, 1'b0, 1'b0, 4'h6}
  };

  logic               tck = 1'b0;
  logic               trst_n = 1'b0;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic               tdo, tdo_oe, pins_hiz, pins_from_bsr;
  logic [BSR_LEN-1:0] pin_in = '0;
  logic [BSR_LEN-1:0] bsr_out;

  int n_chk = 0;
  int n_bad = 0;
  logic oe_seen_ok;

  always #5 tck = ~tck;

  scan_tap #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_oe(tdo_oe), .pin_in(pin_in), .bsr_out(bsr_out),
    .pins_hiz(pins_hiz), .pins_from_bsr(pins_from_bsr)
  );

  function automatic logic [VW-1:0] pat(input int k);
    logic [VW-1:0] v;
    for (int i = 0; i < VW; i++) v[i] = (((i * k) + (i / 3)) % 4) < 2;
    return v;
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // starts and ends in Run-Test/Idle
  task automatic scan(input logic is_ir, input int len,
                      input logic [VW-1:0] din, output logic [VW-1:0] dout);
    dout = '0;
    oe_seen_ok = 1'b1;
    step(1'b1, 1'b0);
    if (is_ir) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      if (!tdo_oe) oe_seen_ok = 1'b0;
      step(i == len - 1, din[i]);
    end
    if (tdo_oe) oe_seen_ok = 1'b0;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [2:0] op, input string req);
    logic [VW-1:0] o;
    scan(1'b1, 3, {125'd0, op}, o);
    check(o[2:0] == 3'b001, req, o[2:0], 3'b001);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [VW-1:0] o, q, p2;
    pin_in = pat(5)[BSR_LEN-1:0];
    pin_in[3:0] = 4'h9;
    #23;
    trst_n = 1'b1;
    @(negedge tck);
    #1;

    // reset state
    check(!tdo_oe && !pins_hiz && !pins_from_bsr, "R9/R3 reset controls",
          {tdo_oe, pins_hiz, pins_from_bsr}, 0);
    check(bsr_out == '0, "R6 bsr_out reset", bsr_out, 0);
    step(1'b0, 1'b0);
    scan(1'b0, 32, '0, o);
    check(o[31:0] == ID_CODE, "R4 idcode after reset", o[31:0], ID_CODE);
    check(oe_seen_ok, "R9 tdo_oe only while shifting", oe_seen_ok, 1);

    // opcode table
    foreach (VECS[k]) begin
      load_ir(VECS[k].op, "R2 capture-ir pattern");
      check({pins_hiz, pins_from_bsr} == {VECS[k].hiz, VECS[k].drv},
            "R5/R7/R8 pin controls per opcode",
            {pins_hiz, pins_from_bsr}, {VECS[k].hiz, VECS[k].drv});
      scan(1'b0, 4, 128'hB, o);
      check(o[3:0] == VECS[k].probe, "R4/R5/R6 selected register probe",
            o[3:0], VECS[k].probe);
    end

    // SAMPLE/PRELOAD: full chain length and preload
    step(1'b1, 1'b0);
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    load_ir(3'b100, "R2 load sample");
    q = pat(7);
    scan(1'b0, BSR_LEN + 1, q, o);
    check(o[BSR_LEN-1:0] == pin_in, "R6 sample captures pin_in", o[BSR_LEN-1:0], pin_in);
    check(o[BSR_LEN] == q[0], "R6 chain is 109 cells", o[BSR_LEN], q[0]);
    check(bsr_out == q[BSR_LEN:1], "R6 preload updates bsr_out", bsr_out, q[BSR_LEN:1]);
    check(!pins_from_bsr && !pins_hiz, "R6 sample leaves pins alone",
          {pins_hiz, pins_from_bsr}, 0);

    // EXTEST
    load_ir(3'b000, "R2 load extest");
    check(pins_from_bsr, "R7 drive after update-ir", pins_from_bsr, 1);
    check(bsr_out == q[BSR_LEN:1], "R7 preloaded vector held", bsr_out, q[BSR_LEN:1]);
    p2 = pat(11);
    pin_in = p2[BSR_LEN-1:0];
    q = pat(3);
    scan(1'b0, BSR_LEN, q, o);
    check(o[BSR_LEN-1:0] == p2[BSR_LEN-1:0], "R7 extest captures pins",
          o[BSR_LEN-1:0], p2[BSR_LEN-1:0]);
    check(bsr_out == q[BSR_LEN-1:0], "R7 extest update", bsr_out, q[BSR_LEN-1:0]);

    // SAMPLE-Z
    load_ir(3'b010, "R2 load sample-z");
    check(pins_hiz && !pins_from_bsr, "R8 outputs forced high-z",
          {pins_hiz, pins_from_bsr}, 2'b10);
    scan(1'b0, BSR_LEN, pat(13), o);
    check(o[BSR_LEN-1:0] == p2[BSR_LEN-1:0], "R8 sample-z captures pins",
          o[BSR_LEN-1:0], p2[BSR_LEN-1:0]);
    check(bsr_out == q[BSR_LEN-1:0], "R8 update ignored under sample-z",
          bsr_out, q[BSR_LEN-1:0]);

    // asynchronous test reset between edges
    trst_n = 1'b0;
    #1;
    check(!pins_hiz && !tdo_oe, "R1/R3 trst clears instruction at once",
          {pins_hiz, tdo_oe}, 0);
    check(bsr_out == '0, "R6 trst clears bsr_out", bsr_out, 0);
    #1;
    trst_n = 1'b1;
    @(negedge tck);
    #1;
    step(1'b0, 1'b0);
    scan(1'b0, 32, '0, o);
    check(o[31:0] == ID_CODE, "R3 idcode after trst", o[31:0], ID_CODE);

    // five TMS highs from inside Shift-DR under EXTEST
    load_ir(3'b000, "R2 load extest again");
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check(tdo_oe, "R9 oe in shift-dr", tdo_oe, 1);
    repeat (4) step(1'b1, 1'b0);
    check(pins_from_bsr, "R1 four highs not yet reset", pins_from_bsr, 1);
    step(1'b1, 1'b0);
    check(!pins_from_bsr && !tdo_oe, "R1/R3 fifth high reaches reset",
          {pins_from_bsr, tdo_oe}, 0);
    step(1'b0, 1'b0);
    scan(1'b0, 32, '0, o);
    check(o[31:0] == ID_CODE, "R3 idcode after tms reset", o[31:0], ID_CODE);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule